// File: doc/BRIEF.md
# Floating-Point Compare to Condition Code Unit

This unit compares two IEEE 754 operands, either both single precision or both double precision, and writes a 2-bit relation code into one of four condition-code fields. Each field keeps its value until a later compare writes it. Branch or select logic in the core reads the fields, and one compare instruction picks which field it writes.

Two compare flavours are offered. The quiet flavour raises invalid only for a signaling NaN. The signaling flavour raises invalid for any NaN. The invalid flag follows the same rules as arithmetic exceptions. When the invalid trap is enabled and invalid is raised, a trap request goes out and the selected field is left untouched. Any unordered result also sets a sticky accrued-invalid bit, whether or not a trap is taken. The unit does no rounding and no arithmetic.

Top module: `fp_cmp_cc`

## Requirements
- R1: The relation code written to a field is 0 for equal, 1 for A less than B, 2 for A greater than B and 3 for unordered (at least one operand is a NaN).
- R2: Ordering follows real values. Negative operands order by reversed magnitude, infinities order at the ends, and +0 and -0 compare equal.
- R3: With `prec_dbl` high the operands are the full 64-bit words. With it low they are bits [31:0] only, and bits [63:32] have no effect on any output.
- R4: A quiet compare (`sig_cmp` low) raises invalid only when an operand is a signaling NaN. A signaling NaN has an all-ones exponent, a nonzero fraction and a fraction MSB of 0. A quiet NaN has a fraction MSB of 1.
- R5: A signaling compare (`sig_cmp` high) raises invalid when either operand is any NaN.
- R6: A compare writes only field `cc_idx`. Field k sits in `cc_fields[2k+1:2k]`, and every other field keeps its value.
- R7: All outputs are registered. Results appear on the clock edge that samples `cmp_valid` high. While `cmp_valid` is low, no output changes except that `trap_req` returns to 0.
- R8: When invalid is raised and `trap_inv_en` is high, `trap_req` pulses high for one cycle and the selected field is not updated.
- R9: `inv_accrued` is set by any unordered result, trapped or not, and is cleared only by reset.
- R10: `inv_flag` takes the invalid outcome of each compare and holds it until the next compare.
- R11: Reset (active-low `rst_n`) clears all fields, `inv_flag`, `inv_accrued` and `trap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare strobe |
| opnd_a | input | 64 | Operand A (single precision in bits [31:0]) |
| opnd_b | input | 64 | Operand B (single precision in bits [31:0]) |
| prec_dbl | input | 1 | 1 selects double precision, 0 single |
| sig_cmp | input | 1 | 1 selects signaling compare, 0 quiet |
| cc_idx | input | 2 | Destination condition-code field |
| trap_inv_en | input | 1 | Invalid trap enable |
| cc_fields | output | 8 | Four 2-bit condition-code fields, field k at [2k+1:2k] |
| inv_flag | output | 1 | Invalid outcome of the latest compare |
| inv_accrued | output | 1 | Sticky accrued-invalid bit |
| trap_req | output | 1 | One-cycle trap request |

## Verification
Every result of this unit is due one edge after the strobe. The fields, `inv_flag`, `inv_accrued` and the `trap_req` pulse all change on the edge that samples `cmp_valid`. The bench drives each compare on a falling edge and drops the strobe on the next falling edge. It samples all outputs at that same later falling edge, which is half a period after the updating edge and while `trap_req` is still high. Idle stretches are sampled on later falling edges to confirm that nothing moves.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int WORD_W    = 1 + DP_EXP_W + DP_FRAC_W;
  localparam int MAG_W     = WORD_W - 1;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             snan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } opnd_t;

  // Relation of two classified operands, real-value ordering.
  function automatic rel_e relate(opnd_t a, opnd_t b);
    logic mag_gt;
    mag_gt = a.mag > b.mag;
    if (a.nan || b.nan)            return REL_UN;
    else if (a.zero && b.zero)     return REL_EQ;
    else if (a.sign != b.sign)     return a.sign ? REL_LT : REL_GT;
    else if (a.mag == b.mag)       return REL_EQ;
    else if (!a.sign)              return mag_gt ? REL_GT : REL_LT;
    else                           return mag_gt ? REL_LT : REL_GT;
  endfunction
endpackage

// File: rtl/fpcc_classify.sv
module fpcc_classify
  import fpcc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output opnd_t                 info
);
  localparam int TOP = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_full;
  logic              frac_nz;

  assign exp_f    = word[TOP-1:FRAC_W];
  assign frac_f   = word[FRAC_W-1:0];
  assign exp_full = &exp_f;
  assign frac_nz  = |frac_f;

  always_comb begin
    info.sign = word[TOP];
    info.nan  = exp_full && frac_nz;
    info.snan = exp_full && frac_nz && !frac_f[FRAC_W-1];
    info.zero = !(|exp_f) && !frac_nz;
    info.mag  = MAG_W'(word[TOP-1:0]);
  end
endmodule

// File: rtl/fpcc_bank.sv
module fpcc_bank #(
  parameter int FIELDS = 4,
  parameter int IDX_W  = $clog2(FIELDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [1:0]            wr_code,
  output logic [2*FIELDS-1:0]   fields
);
  for (genvar k = 0; k < FIELDS; k++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n)
        fields[2*k+1:2*k] <= 2'd0;
      else if (wr_en && (wr_idx == IDX_W'(k)))
        fields[2*k+1:2*k] <= wr_code;
    end
  end
endmodule

// File: rtl/fp_cmp_cc.sv
module fp_cmp_cc
  import fpcc_pkg::*;
#(
  parameter int FIELDS = 4,
  parameter int IDX_W  = $clog2(FIELDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmp_valid,
  input  logic [63:0]          opnd_a,
  input  logic [63:0]          opnd_b,
  input  logic                 prec_dbl,
  input  logic                 sig_cmp,
  input  logic [IDX_W-1:0]     cc_idx,
  input  logic                 trap_inv_en,
  output logic [2*FIELDS-1:0]  cc_fields,
  output logic                 inv_flag,
  output logic                 inv_accrued,
  output logic                 trap_req
);
  localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W;

  logic [63:0] opw [2];
  opnd_t       sp_i [2];
  opnd_t       dp_i [2];
  opnd_t       sel_i [2];

  assign opw[0] = opnd_a;
  assign opw[1] = opnd_b;

  for (genvar k = 0; k < 2; k++) begin : g_op
    fpcc_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
      .word (opw[k][SP_W-1:0]),
      .info (sp_i[k])
    );
    fpcc_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
      .word (opw[k]),
      .info (dp_i[k])
    );
    assign sel_i[k] = prec_dbl ? dp_i[k] : sp_i[k];
  end

  // Named internal events
  rel_e cmp_rel;
  logic cmp_any_nan;
  logic cmp_any_snan;
  logic cmp_invalid;
  logic trap_hit;
  logic cc_write;

  assign cmp_rel      = relate(sel_i[0], sel_i[1]);
  assign cmp_any_nan  = sel_i[0].nan  || sel_i[1].nan;
  assign cmp_any_snan = sel_i[0].snan || sel_i[1].snan;
  assign cmp_invalid  = sig_cmp ? cmp_any_nan : cmp_any_snan;
  assign trap_hit     = cmp_invalid && trap_inv_en;
  assign cc_write     = cmp_valid && !trap_hit;

  fpcc_bank #(.FIELDS(FIELDS), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cc_write),
    .wr_idx  (cc_idx),
    .wr_code (cmp_rel),
    .fields  (cc_fields)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_flag    <= 1'b0;
      inv_accrued <= 1'b0;
      trap_req    <= 1'b0;
    end else begin
      trap_req <= cmp_valid && trap_hit;
      if (cmp_valid) begin
        inv_flag <= cmp_invalid;
        if (cmp_rel == REL_UN)
          inv_accrued <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpcc_checker.sv
module fpcc_checker #(
  parameter int FIELDS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmp_valid,
  input logic                cmp_invalid,
  input logic [2*FIELDS-1:0] cc_fields,
  input logic                inv_flag,
  input logic                inv_accrued,
  input logic                trap_req
);
  // R8
  trap_keeps_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $stable(cc_fields));

  // R8
  trap_needs_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> inv_flag);

  // R9
  accrued_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(inv_accrued));

  // R9
  invalid_accrues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_flag |-> inv_accrued);

  // R7
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> ($stable(cc_fields) && $stable(inv_flag) && !trap_req));

  // R6
  one_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc_fields ^ $past(cc_fields)) <= 2);

  // R10
  inv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_invalid) |=> inv_flag);

  // R10
  inv_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_invalid) |=> !inv_flag);
endmodule

bind fp_cmp_cc fpcc_checker #(.FIELDS(FIELDS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmp_valid   (cmp_valid),
  .cmp_invalid (cmp_invalid),
  .cc_fields   (cc_fields),
  .inv_flag    (inv_flag),
  .inv_accrued (inv_accrued),
  .trap_req    (trap_req)
);

// File: tb/sim_fp_cmp_cc.sv
module sim_fp_cmp_cc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_valid;
  logic [63:0] opnd_a, opnd_b;
  logic        prec_dbl, sig_cmp, trap_inv_en;
  logic [1:0]  cc_idx;
  logic [7:0]  cc_fields;
  logic        inv_flag, inv_accrued, trap_req;

  int n_tests = 0;
  int n_fail  = 0;
  logic [1:0] m_cc [4];
  logic m_inv, m_acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_cmp_cc u0 (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .prec_dbl(prec_dbl), .sig_cmp(sig_cmp), .cc_idx(cc_idx),
    .trap_inv_en(trap_inv_en), .cc_fields(cc_fields), .inv_flag(inv_flag),
    .inv_accrued(inv_accrued), .trap_req(trap_req)
  );

  // single precision constants
  localparam logic [31:0] S_P1 = 32'h3F800000, S_P2 = 32'h40000000,
                          S_P3 = 32'h40400000, S_M1 = 32'hBF800000,
                          S_M2 = 32'hC0000000, S_NZ = 32'h80000000,
                          S_QN = 32'h7FC00000, S_SN = 32'h7F800001,
                          S_INF = 32'h7F800000;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_pack();
    return {m_cc[3], m_cc[2], m_cc[1], m_cc[0]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmp_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) m_cc[k] = 2'd0;
    m_inv = 1'b0; m_acc = 1'b0;
  endtask

  // One compare; code/inv are the expected outcome from the requirements.
  task automatic run_cmp(string req, logic [63:0] a, logic [63:0] b, logic dbl,
                         logic sig, logic [1:0] idx, logic ten,
                         logic [1:0] code, logic inv);
    logic trap;
    trap = inv && ten;
    cmp_valid = 1'b1; opnd_a = a; opnd_b = b; prec_dbl = dbl;
    sig_cmp = sig; cc_idx = idx; trap_inv_en = ten;
    @(negedge clk);
    cmp_valid = 1'b0;
    if (!trap) m_cc[idx] = code;
    m_inv = inv;
    if (code == 2'd3) m_acc = 1'b1;
    check({req, " fields"},   64'(cc_fields),   64'(model_pack()));
    check({req, " inv_flag"}, 64'(inv_flag),    64'(m_inv));
    check({req, " accrued"},  64'(inv_accrued), 64'(m_acc));
    check({req, " trap"},     64'(trap_req),    64'(trap));
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 fields", 64'(cc_fields), 64'd0);
    check("R11 flags", {61'd0, inv_flag, inv_accrued, trap_req}, 64'd0);
  endtask

  task automatic t_single_order();
    run_cmp("R1 lt",  {32'd0, S_P1}, {32'd0, S_P2}, 0, 0, 2'd0, 0, 2'd1, 0);
    run_cmp("R1 gt",  {32'd0, S_P2}, {32'd0, S_P1}, 0, 0, 2'd1, 0, 2'd2, 0);
    run_cmp("R1 eq",  {32'd0, S_P3}, {32'd0, S_P3}, 0, 0, 2'd2, 0, 2'd0, 0);
    run_cmp("R2 neg", {32'd0, S_M2}, {32'd0, S_M1}, 0, 0, 2'd3, 0, 2'd1, 0);
    run_cmp("R2 sgn", {32'd0, S_M1}, {32'd0, S_P1}, 0, 0, 2'd0, 0, 2'd1, 0);
    run_cmp("R2 zero", 64'd0, {32'd0, S_NZ}, 0, 0, 2'd1, 0, 2'd0, 0);
    run_cmp("R2 inf", {32'd0, S_INF}, {32'd0, S_P1}, 0, 1, 2'd2, 0, 2'd2, 0);
  endtask

  task automatic t_double();
    run_cmp("R3 dbl", 64'h3FF0000000000000, 64'h0000000000000001, 1, 0, 2'd3, 0, 2'd2, 0);
    run_cmp("R3 sgl", 64'h3FF0000000000000, 64'h0000000000000001, 0, 0, 2'd2, 0, 2'd1, 0);
    run_cmp("R2 dzero", 64'h8000000000000000, 64'd0, 1, 0, 2'd1, 0, 2'd0, 0);
    run_cmp("R1 dlt", 64'h3FF0000000000000, 64'h4000000000000000, 1, 0, 2'd0, 0, 2'd1, 0);
    run_cmp("R3 upper", {32'hFFFFFFFF, S_P1}, {32'h7FF80000, S_P2}, 0, 1, 2'd1, 1, 2'd1, 0);
  endtask

  task automatic t_idle();
    logic [7:0] snap;
    snap = cc_fields;
    opnd_a = {32'd0, S_QN}; opnd_b = 64'd0; cc_idx = 2'd3;
    sig_cmp = 1'b1; trap_inv_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 idle fields", 64'(cc_fields), 64'(snap));
    check("R7 idle flags", {62'd0, inv_accrued, trap_req}, 64'd0);
  endtask

  task automatic t_quiet_nan();
    run_cmp("R4 qnan", {32'd0, S_QN}, {32'd0, S_P1}, 0, 0, 2'd0, 0, 2'd3, 0);
    run_cmp("R4 snan", {32'd0, S_P1}, {32'd0, S_SN}, 0, 0, 2'd2, 0, 2'd3, 1);
    run_cmp("R10 clear", {32'd0, S_P1}, {32'd0, S_P1}, 0, 0, 2'd2, 0, 2'd0, 0);
    check("R9 sticky", 64'(inv_accrued), 64'd1);
  endtask

  task automatic t_signaling();
    do_reset();
    run_cmp("R5 ord", {32'd0, S_P1}, {32'd0, S_P2}, 0, 1, 2'd0, 0, 2'd1, 0);
    run_cmp("R5 qnan", {32'd0, S_QN}, {32'd0, S_P2}, 0, 1, 2'd1, 0, 2'd3, 1);
    run_cmp("R4 dsnan", 64'h7FF0000000000001, 64'd0, 1, 0, 2'd2, 0, 2'd3, 1);
    run_cmp("R3 dnan sgl", 64'h7FF8000000000000, 64'd0, 0, 1, 2'd3, 0, 2'd0, 0);
  endtask

  task automatic t_trap();
    do_reset();
    run_cmp("R8 pre", {32'd0, S_P2}, {32'd0, S_P1}, 0, 1, 2'd1, 1, 2'd2, 0);
    run_cmp("R8 trap", {32'd0, S_QN}, {32'd0, S_P1}, 0, 1, 2'd1, 1, 2'd3, 1);
    @(negedge clk);
    check("R8 pulse", 64'(trap_req), 64'd0);
    run_cmp("R8 dtrap", 64'h7FF0000000000001, 64'd0, 1, 0, 2'd2, 1, 2'd3, 1);
    run_cmp("R4 quiet noinv", {32'd0, S_QN}, {32'd0, S_P1}, 0, 0, 2'd3, 1, 2'd3, 0);
  endtask

  initial begin
    rst_n = 1'b0; cmp_valid = 1'b0; opnd_a = '0; opnd_b = '0;
    prec_dbl = 1'b0; sig_cmp = 1'b0; cc_idx = '0; trap_inv_en = 1'b0;
    t_reset();
    t_single_order();
    t_double();
    t_idle();
    t_quiet_nan();
    t_signaling();
    t_trap();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule